// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. It sits on a small byte-wide register bus of a microcontroller. It drives a channel select to an external analog multiplexer, a sample strobe to the hold stage, and a trial code to an external capacitor DAC. It reads back one comparator bit, which is 1 when the held input is at or above the DAC level. The controller runs a binary search from the most significant bit down to the least. When the search ends, the code goes into a read-only result register and a completion flag rises.

Software sees two registers. The result register is at offset 0x08. The control register is at offset 0x09. Writing the control register always cancels any conversion in flight and clears the completion flag. If the written value has the enable bit set, a fresh conversion starts on the newly chosen channel. A clock-source select bit is stored and read back but has no effect on the sequence.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After synchronous reset, the control register reads 0x00 (enable and clock-select clear, so the converter is off), the result register reads 0x00, the sample strobe is low, and the trial code is 0x00.
- R2: A control write with the enable bit (bit 5) set raises the sample strobe in the cycle after the write edge and holds it for exactly SAMPLE_CYC cycles.
- R3: When sampling ends, the first trial code is 0x80. Each bit stays on trial for two cycles: one settle cycle and one compare cycle. At the end of the compare cycle the bit is kept if the comparator reads 1 and cleared otherwise, and the next lower bit is put on trial.
- R4: The result register and the completion flag (control bit 7) update at the edge SAMPLE_CYC + 16 cycles after the starting write edge, and the flag is still 0 one cycle before.
- R5: The result equals the held input level clamped to the range 0x00 to 0xFF. An input at or above the high reference yields 0xFF, and an input at or below the low reference yields 0x00.
- R6: The channel field (bits 3:0) drives the channel select output directly. Codes 0 to 5 pick external inputs, 6 the high reference, 7 the mid reference and 8 the low reference.
- R7: Any control write, including one that lands on the edge where a conversion would finish, clears the completion flag. The interrupted conversion never updates the result register, and a new conversion starts on the channel just written.
- R8: A control write with the enable bit clear stops the sequencer (no sample strobe, trial code 0x00) and only updates the fields. The result register and the completion flag stay unchanged apart from the flag clearing.
- R9: Reading the result register or the control register does not clear the completion flag.
- R10: A write to offset 0x08 is ignored, and the result register keeps its value.
- R11: The clock-select bit (bit 6) is stored by a control write and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| chan_sel | output | 4 | Analog multiplexer channel code |
| sample_en | output | 1 | High while the input is being sampled |
| dac_code | output | DATA_W | Trial code for the external DAC |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |

## Verification
A control write taken at edge E starts the sample strobe in the following cycle. The first trial code of 0x80 appears after edge E+SAMPLE_CYC, and the code steps down once every two cycles after that. The result register and the completion flag change at edge E+SAMPLE_CYC+16. The driver records the bench cycle of each write edge and queues the expected result together with that due cycle. The monitor reads the registers at the falling edge just after the due edge, and also one cycle earlier to confirm that the flag has not yet risen. When a conversion is cut short, its queued item is replaced by a check at the old due cycle that the result is unchanged and the flag is low. This lets an abort that coincides with the final compare edge be checked precisely.

// File: rtl/sar_adc_pkg.sv
// Package: shared constants and types for the successive-approximation controller.
// Assumes an 8-bit register bus with the result and control registers at fixed offsets.
package sar_adc_pkg;
    localparam int OFS_RESULT = 8;   // read-only result register offset
    localparam int OFS_CTRL   = 9;   // control/status register offset
    localparam int CHAN_W     = 4;   // channel field width
    localparam int CTL_DONE   = 7;   // completion flag bit
    localparam int CTL_CLKSEL = 6;   // clock-select bit
    localparam int CTL_ON     = 5;   // converter enable bit

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_COMPARE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sar_adc_regs.sv
// Module: register file and bus decode for the converter.
// Holds the control fields, the completion flag and the result; control writes
// take priority over a finishing conversion. Assumes reads are combinational.
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_val,
    output logic              ctrl_wr,
    output logic              wr_on,
    output logic              done_q,
    output logic              on_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic [DATA_W-1:0] result_q
);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RESULT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic clksel_q;
    logic unused_wbits;
    logic [DATA_W-1:0] ctrl_view;

    // Decode a control-register write and the enable bit it carries.
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign wr_on   = bus_wdata[CTL_ON];
    assign unused_wbits = bus_wdata[CTL_DONE] ^ bus_wdata[CHAN_W];

    // Update fields on a control write; otherwise capture a finished conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            on_q     <= 1'b0;
            clksel_q <= 1'b0;
            chan_q   <= '0;
            result_q <= '0;
        end else if (ctrl_wr) begin
            done_q   <= 1'b0;
            on_q     <= bus_wdata[CTL_ON];
            clksel_q <= bus_wdata[CTL_CLKSEL];
            chan_q   <= bus_wdata[CHAN_W-1:0];
        end else if (conv_done) begin
            done_q   <= 1'b1;
            result_q <= conv_val;
        end
    end

    // Assemble the control register as software reads it.
    always_comb begin
        ctrl_view             = '0;
        ctrl_view[CHAN_W-1:0] = chan_q;
        ctrl_view[CTL_ON]     = on_q;
        ctrl_view[CTL_CLKSEL] = clksel_q;
        ctrl_view[CTL_DONE]   = done_q;
    end

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        if (bus_addr == A_RES)       bus_rdata = result_q;
        else if (bus_addr == A_CTRL) bus_rdata = ctrl_view;
        else                         bus_rdata = '0;
    end
endmodule

// File: rtl/sar_adc_seq.sv
// Module: binary-search sequencer.
// Samples for SAMPLE_CYC cycles, then trials each bit MSB first with one settle
// and one compare cycle. A restart aborts at any point. Assumes cmp_in is valid
// in the compare cycle for the code on dac_code.
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SAMPLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             start_on,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             sample_en,
    output logic             conv_done,
    output logic [WIDTH-1:0] conv_val
);
    localparam int CNT_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [WIDTH-1:0] sar_q;
    logic [WIDTH-1:0] trial_mask;
    logic [WIDTH-1:0] sar_kept;

    // One-hot mask of the bit currently on trial.
    for (genvar g = 0; g < WIDTH; g++) begin : g_mask
        assign trial_mask[g] = (idx_q == IDX_W'(g));
    end

    // Keep or drop the trial bit according to the comparator.
    assign sar_kept  = cmp_in ? sar_q : (sar_q & ~trial_mask);
    assign dac_code  = sar_q;
    assign sample_en = (state_q == ST_SAMPLE);
    assign conv_done = (state_q == ST_COMPARE) && (idx_q == '0) && !restart;
    assign conv_val  = sar_kept;

    // Sequence state, sample counter, bit index and approximation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sar_q   <= '0;
        end else if (restart) begin
            state_q <= start_on ? ST_SAMPLE : ST_IDLE;
            cnt_q   <= CNT_W'(SAMPLE_CYC - 1);
            idx_q   <= TOP_IDX;
            sar_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sar_q <= '0;
                end
                ST_SAMPLE: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_SETTLE;
                        idx_q   <= TOP_IDX;
                        sar_q   <= {1'b1, {(WIDTH-1){1'b0}}};
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_SETTLE: begin
                    state_q <= ST_COMPARE;
                end
                ST_COMPARE: begin
                    if (idx_q == '0) begin
                        state_q <= ST_IDLE;
                        sar_q   <= '0;
                    end else begin
                        state_q <= ST_SETTLE;
                        idx_q   <= idx_q - 1'b1;
                        sar_q   <= sar_kept | (trial_mask >> 1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: top of the converter control logic.
// Joins the register file and the sequencer. A control write restarts the
// sequencer; the analog parts sit outside and close the loop through cmp_in.
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int SAMPLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              sample_en,
    output logic [DATA_W-1:0] dac_code,
    input  logic              cmp_in
);
    logic              ctrl_wr;
    logic              wr_on;
    logic              done_q;
    logic              on_q;
    logic [DATA_W-1:0] result_q;
    logic              conv_done;
    logic [DATA_W-1:0] conv_val;

    sar_adc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .conv_done(conv_done), .conv_val(conv_val),
        .ctrl_wr(ctrl_wr), .wr_on(wr_on),
        .done_q(done_q), .on_q(on_q), .chan_q(chan_sel), .result_q(result_q)
    );

    sar_adc_seq #(.WIDTH(DATA_W), .SAMPLE_CYC(SAMPLE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .restart(ctrl_wr), .start_on(wr_on), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_en(sample_en),
        .conv_done(conv_done), .conv_val(conv_val)
    );
endmodule

// File: rtl/sar_adc_chk.sv
// Module: protocol checker bound to the converter top.
// Observes ports and the nets between the register file and the sequencer.
module sar_adc_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              sample_en,
    input logic [DATA_W-1:0] dac_code,
    input logic              done_q,
    input logic              on_q,
    input logic              conv_done,
    input logic [DATA_W-1:0] result_q
);
    localparam logic [DATA_W-1:0] MSB_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    p_start_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_en) |-> $past(ctrl_wr));

    p_sample_needs_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> on_q);

    p_first_trial_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_en) && !$past(ctrl_wr)) |-> (dac_code == MSB_CODE));

    p_done_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> done_q);

    p_write_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !done_q);

    p_result_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(result_q));
endmodule

bind sar_adc_ctrl sar_adc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .sample_en(sample_en),
    .dac_code(dac_code), .done_q(done_q), .on_q(on_q),
    .conv_done(conv_done), .result_q(result_q)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/100ps
// Bench: scoreboard for the converter controller with a behavioural analog model.
module sim_sar_adc_ctrl;
    localparam int S = 4;
    localparam int L = S + 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h9;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] chan_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic       cmp_in;

    int   vectors = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   finished = 1'b0;

    int   ana [0:8];
    int   held = 0;

    int        q_due [$];
    logic [7:0] q_exp [$];
    bit        q_coco [$];
    string     q_tag [$];

    bit         pend_valid = 1'b0;
    int         pend_due = 0;
    logic [7:0] pend_exp = 8'h00;
    logic [7:0] committed = 8'h00;

    sar_adc_ctrl #(.DATA_W(8), .ADDR_W(4), .SAMPLE_CYC(S)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_sel(chan_sel),
        .sample_en(sample_en), .dac_code(dac_code), .cmp_in(cmp_in)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Analog model: hold the selected level while sampling, compare against the DAC code.
    always @(posedge clk) if (sample_en) held <= (chan_sel < 9) ? ana[chan_sel] : 0;
    assign cmp_in = (held >= int'(dac_code));

    function automatic logic [7:0] clamp8(input int v);
        if (v >= 255) return 8'hFF;
        if (v <= 0) return 8'h00;
        return 8'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.3;
        d = bus_rdata;
        bus_addr = 4'h9;
    endtask

    // Driver: one control write, with the expected outcome queued by due cycle.
    task automatic ctrl_write(input logic [7:0] v);
        int c;
        @(negedge clk);
        c = cyc;
        bus_addr = 4'h9; bus_wdata = v; bus_wr = 1'b1;
        if (pend_valid && pend_due <= c) begin
            committed = pend_exp; pend_valid = 1'b0;
        end
        if (pend_valid) begin
            void'(q_due.pop_back()); void'(q_exp.pop_back());
            void'(q_coco.pop_back()); void'(q_tag.pop_back());
            q_due.push_back(pend_due); q_exp.push_back(committed);
            q_coco.push_back(1'b0); q_tag.push_back("R7 aborted");
            pend_valid = 1'b0;
        end
        if (v[5]) begin
            pend_exp = (v[3:0] < 9) ? clamp8(ana[v[3:0]]) : 8'h00;
            pend_due = c + 1 + L; pend_valid = 1'b1;
            q_due.push_back(pend_due); q_exp.push_back(pend_exp);
            q_coco.push_back(1'b1); q_tag.push_back("R4/R5");
        end else begin
            q_due.push_back(c + 1 + L); q_exp.push_back(committed);
            q_coco.push_back(1'b0); q_tag.push_back("R8 off");
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (q_due.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare registers at the due cycle, and the flag one cycle earlier.
    initial begin
        logic [7:0] r, s;
        forever begin
            @(negedge clk);
            #0.1;
            if (q_due.size() != 0) begin
                if (q_coco[0] && cyc == q_due[0] - 1) begin
                    rd(4'h9, s);
                    check("R4 flag not early", int'(s[7]), 0);
                end
                if (cyc >= q_due[0]) begin
                    rd(4'h8, r);
                    rd(4'h9, s);
                    check({q_tag[0], " result"}, int'(r), int'(q_exp[0]));
                    check({q_tag[0], " flag"}, int'(s[7]), int'(q_coco[0]));
                    if (q_coco[0]) committed = q_exp[0];
                    void'(q_due.pop_front()); void'(q_exp.pop_front());
                    void'(q_coco.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        ana[0] = 17; ana[1] = 195; ana[2] = 254; ana[3] = 90; ana[4] = 165; ana[5] = 1;
        ana[6] = 255; ana[7] = 128; ana[8] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h9, d); check("R1 ctrl", d, 8'h00);
        rd(4'h8, d); check("R1 result", d, 8'h00);
        check("R1 sample", sample_en, 0);
        check("R1 dac", dac_code, 0);

        // R11, R6, R8: fields update with the converter off
        ctrl_write(8'h42);
        rd(4'h9, d); check("R11 readback", d, 8'h42);
        check("R6 chan_sel", chan_sel, 2);
        check("R8 no sample", sample_en, 0);
        wait_idle();

        // R2, R3: strobe length and trial codes
        ctrl_write(8'h23);
        n = 0;
        while (sample_en && n < 100) begin n++; @(negedge clk); end
        check("R2 sample length", n, S);
        check("R3 first trial", dac_code, 8'h80);
        check("R6 chan_sel", chan_sel, 3);
        repeat (2) @(negedge clk);
        check("R3 second trial", dac_code, 8'h40);
        wait_idle();

        // R9 reads keep the flag; R10 result is read-only
        rd(4'h8, d); rd(4'h8, d);
        rd(4'h9, d); check("R9 flag after reads", d[7], 1);
        @(negedge clk);
        bus_addr = 4'h8; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h9;
        rd(4'h8, d); check("R10 result kept", d, 8'd90);
        rd(4'h9, d); check("R10 flag kept", d[7], 1);

        // R5, R6 references and saturation
        for (int ch = 4; ch < 9; ch++) begin ctrl_write(8'h20 | 8'(ch)); wait_idle(); end
        ana[0] = 300; ctrl_write(8'h20); wait_idle();
        ana[1] = -20; ctrl_write(8'h21); wait_idle();
        ctrl_write(8'h22); wait_idle();

        // R7 aborts: mid-search, mid-sample, and on the finishing edge
        ana[0] = 17; ana[1] = 195;
        ctrl_write(8'h20); repeat (7) @(negedge clk); ctrl_write(8'h21); wait_idle();
        ctrl_write(8'h20); ctrl_write(8'h21); wait_idle();
        ctrl_write(8'h20); repeat (L - 2) @(negedge clk); ctrl_write(8'h21); wait_idle();

        // R8 disable during a conversion
        ctrl_write(8'h24); repeat (5) @(negedge clk);
        ctrl_write(8'h04);
        check("R8 sample off", sample_en, 0);
        check("R8 dac idle", dac_code, 0);
        wait_idle();
        rd(4'h9, d); check("R8 ctrl fields", d, 8'h04);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule